// File: doc/BRIEF.md
# Two-Wire Serial Mode and Completion-Flag Controller

This block sits next to a two-wire serial byte engine and holds its control state and its status flags. Its first job is the operating mode. Software can move the port from the framed bus format into an unframed mode by writing a switch bit. The block returns to the framed format by itself as soon as it sees a falling edge on the clock line. On that return it puts the port into slave mode with the direction set to receive, so that the port is ready for a slave address.

Its second job is the per-byte status. When a byte finishes, the block sets completion flags according to the received acknowledge bit and an acknowledge-check enable. The transfer-request flag drives a trigger for an external transfer engine. When the engine reports that it is done, all flags are cleared together, so the processor is not interrupted during a chained transfer. A byte that is refused under the acknowledge check raises only the interrupt flag. This stops the chain and hands control back to software.

Top module: `twsm_ctrl`

## Requirements
- R1: After reset, fmtless, master, dir, all three flags, xfer_trig and irq are 0, and both enables (ack_chk, irq_en) are 0.
- R2: A write to address 1 loads wr_data[0] into the switch bit, which is output as fmtless (1 = unframed mode).
- R3: While fmtless is 1, a falling edge on scl_in (sampled 1, then 0, through a two-stage synchronizer) clears fmtless on the third rising clock edge after scl_in falls. A rising edge, or a low level that was already present when fmtless was set, does not clear it.
- R4: On that automatic return, master and dir are both forced to 0 (slave, receive).
- R5: A write to address 0 loads master = wr_data[0], dir = wr_data[1], ack_chk = wr_data[2] and irq_en = wr_data[3]. While fmtless is 1, the master and dir fields of such a write are ignored, but ack_chk and irq_en are still loaded.
- R6: While fmtless is 0, edges on scl_in have no effect on fmtless, master or dir.
- R7: With ack_chk = 0, a byte_done pulse sets flag_empty, flag_irq and flag_xfer, whatever the value of ack_bit.
- R8: With ack_chk = 1 and ack_bit = 0, a byte_done pulse sets all three flags.
- R9: With ack_chk = 1 and ack_bit = 1, a byte_done pulse sets only flag_irq; flag_xfer and xfer_trig stay 0.
- R10: xfer_trig follows flag_xfer. An eng_done pulse clears all three flags on the next edge.
- R11: irq = flag_irq AND irq_en, held at 0 while xfer_trig is 1.
- R12: A write to address 2 clears flag_empty, flag_irq or flag_xfer when wr_data bit 0, 1 or 2 respectively is 0. A 1 in such a bit leaves the flag unchanged. A byte_done set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 switch, 2 flag clear |
| wr_data | input | 4 | Write data |
| scl_in | input | 1 | Raw serial clock line level |
| byte_done | input | 1 | One-cycle pulse at the end of a byte |
| ack_bit | input | 1 | Acknowledge bit received with byte_done |
| eng_done | input | 1 | One-cycle pulse from the transfer engine |
| fmtless | output | 1 | Switch bit; 1 = unframed mode |
| master | output | 1 | 1 = master, 0 = slave |
| dir | output | 1 | 1 = transmit, 0 = receive |
| flag_empty | output | 1 | Data-register-empty flag |
| flag_irq | output | 1 | Interrupt flag |
| flag_xfer | output | 1 | Transfer-request flag |
| xfer_trig | output | 1 | Trigger to the transfer engine |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that byte_done and eng_done are single-cycle pulses that come from the serial engine and the transfer engine. They also assume that only the block's own logic can set the flags. The flag properties therefore treat any set that the byte_done gating cannot explain as an error. The bench keeps to these assumptions: it drives each pulse for exactly one cycle on the falling clock edge and never overlaps a pulse with a write unless the test is about that collision. It holds scl_in steady for several cycles around each edge, so that the synchronizer delay is the only latency it has to account for.

// File: rtl/twsm_pkg.sv
package twsm_pkg;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 4;
  localparam int N_FLAGS = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_SWITCH = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 2'd2;

  localparam int F_EMPTY = 0;
  localparam int F_IRQ   = 1;
  localparam int F_XFER  = 2;

  localparam int C_MASTER = 0;
  localparam int C_DIR    = 1;
  localparam int C_ACKCHK = 2;
  localparam int C_IRQEN  = 3;

  typedef struct packed {
    logic ctrl;
    logic sw;
    logic flags;
  } wr_sel_t;

  function automatic wr_sel_t decode_wr(input logic en, input logic [ADDR_W-1:0] a);
    wr_sel_t s;
    s.ctrl  = en && (a == A_CTRL);
    s.sw    = en && (a == A_SWITCH);
    s.flags = en && (a == A_FLAGS);
    return s;
  endfunction

  // Flags raised at byte end: interrupt always; the other two only when
  // the acknowledge check is off or the byte was acknowledged.
  function automatic logic [N_FLAGS-1:0] byte_set_mask(input logic chk, input logic nack);
    logic [N_FLAGS-1:0] m;
    logic accepted;
    accepted   = !(chk && nack);
    m          = '0;
    m[F_IRQ]   = 1'b1;
    m[F_EMPTY] = accepted;
    m[F_XFER]  = accepted;
    return m;
  endfunction
endpackage

// File: rtl/twsm_scl_sync.sv
module twsm_scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic detect_en,
  output logic scl_fall
);
  logic [STAGES-1:0] chain;
  logic              scl_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= scl_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_prev <= 1'b1;
    else        scl_prev <= chain[STAGES-1];
  end

  assign scl_fall = detect_en && scl_prev && !chain[STAGES-1];
endmodule

// File: rtl/twsm_mode_reg.sv
module twsm_mode_reg
  import twsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_sw,
  input  logic [DATA_W-1:0] wdata,
  input  logic              scl_fall,
  output logic              fmtless,
  output logic              master,
  output logic              dir,
  output logic              ack_chk,
  output logic              irq_en
);
  logic role_wr;
  assign role_wr = wr_ctrl && !fmtless;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fmtless <= 1'b0;
    else if (scl_fall) fmtless <= 1'b0;
    else if (wr_sw)    fmtless <= wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master <= 1'b0;
      dir    <= 1'b0;
    end else if (scl_fall) begin
      master <= 1'b0;
      dir    <= 1'b0;
    end else if (role_wr) begin
      master <= wdata[C_MASTER];
      dir    <= wdata[C_DIR];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_chk <= 1'b0;
      irq_en  <= 1'b0;
    end else if (wr_ctrl) begin
      ack_chk <= wdata[C_ACKCHK];
      irq_en  <= wdata[C_IRQEN];
    end
  end
endmodule

// File: rtl/twsm_flag_bank.sv
module twsm_flag_bank
  import twsm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_done,
  input  logic               ack_bit,
  input  logic               ack_chk,
  input  logic               eng_done,
  input  logic               wr_flags,
  input  logic [N_FLAGS-1:0] wdata,
  output logic [N_FLAGS-1:0] flags,
  output logic [N_FLAGS-1:0] hw_set
);
  assign hw_set = byte_done ? byte_set_mask(ack_chk, ack_bit) : '0;

  genvar i;
  generate
    for (i = 0; i < N_FLAGS; i++) begin : g_flag
      logic drop;
      assign drop = eng_done || (wr_flags && !wdata[i]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flags[i] <= 1'b0;
        else if (hw_set[i]) flags[i] <= 1'b1;
        else if (drop)      flags[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/twsm_ctrl.sv
module twsm_ctrl
  import twsm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              scl_in,
  input  logic              byte_done,
  input  logic              ack_bit,
  input  logic              eng_done,
  output logic              fmtless,
  output logic              master,
  output logic              dir,
  output logic              flag_empty,
  output logic              flag_irq,
  output logic              flag_xfer,
  output logic              xfer_trig,
  output logic              irq
);
  wr_sel_t            sel;
  logic               scl_fall;
  logic               ack_chk;
  logic               irq_en;
  logic [N_FLAGS-1:0] flags;
  logic [N_FLAGS-1:0] hw_set;

  assign sel = decode_wr(wr_en, wr_addr);

  twsm_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_in),
    .detect_en(fmtless), .scl_fall(scl_fall)
  );

  twsm_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(sel.ctrl), .wr_sw(sel.sw),
    .wdata(wr_data), .scl_fall(scl_fall), .fmtless(fmtless),
    .master(master), .dir(dir), .ack_chk(ack_chk), .irq_en(irq_en)
  );

  twsm_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .ack_bit(ack_bit),
    .ack_chk(ack_chk), .eng_done(eng_done), .wr_flags(sel.flags),
    .wdata(wr_data[N_FLAGS-1:0]), .flags(flags), .hw_set(hw_set)
  );

  assign flag_empty = flags[F_EMPTY];
  assign flag_irq   = flags[F_IRQ];
  assign flag_xfer  = flags[F_XFER];
  assign xfer_trig  = flag_xfer;
  assign irq        = flag_irq && irq_en && !xfer_trig;
endmodule

// File: rtl/twsm_ctrl_chk.sv
module twsm_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic fmtless,
  input logic master,
  input logic dir,
  input logic scl_fall,
  input logic byte_done,
  input logic ack_bit,
  input logic ack_chk,
  input logic eng_done,
  input logic flag_empty,
  input logic flag_irq,
  input logic flag_xfer,
  input logic xfer_trig,
  input logic irq
);
  p_auto_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> !fmtless);

  p_slave_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> (!master && !dir));

  p_role_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fmtless && !scl_fall) |=> ($stable(master) && $stable(dir)));

  p_no_edge_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fmtless |-> !scl_fall);

  p_set_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !ack_chk) |=> (flag_empty && flag_irq && flag_xfer));

  p_set_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ack_chk && !ack_bit) |=> (flag_empty && flag_irq && flag_xfer));

  p_nack_no_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ack_chk && ack_bit && !flag_xfer) |=> (flag_irq && !xfer_trig));

  p_engine_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !byte_done) |=> (!flag_empty && !flag_irq && !flag_xfer));

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_irq && !xfer_trig));
endmodule

bind twsm_ctrl twsm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmtless(fmtless), .master(master), .dir(dir),
  .scl_fall(scl_fall), .byte_done(byte_done), .ack_bit(ack_bit),
  .ack_chk(ack_chk), .eng_done(eng_done), .flag_empty(flag_empty),
  .flag_irq(flag_irq), .flag_xfer(flag_xfer), .xfer_trig(xfer_trig), .irq(irq)
);

// File: tb/twsm_ctrl_test.sv
`timescale 1ns/1ps
module twsm_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [3:0] wr_data = 4'd0;
  logic       scl_in = 1'b1;
  logic       byte_done = 1'b0;
  logic       ack_bit = 1'b0;
  logic       eng_done = 1'b0;
  logic fmtless, master, dir, flag_empty, flag_irq, flag_xfer, xfer_trig, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  twsm_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .scl_in(scl_in), .byte_done(byte_done),
    .ack_bit(ack_bit), .eng_done(eng_done), .fmtless(fmtless),
    .master(master), .dir(dir), .flag_empty(flag_empty), .flag_irq(flag_irq),
    .flag_xfer(flag_xfer), .xfer_trig(xfer_trig), .irq(irq)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic byte_end(input logic a);
    @(negedge clk);
    byte_done = 1'b1; ack_bit = a;
    @(negedge clk);
    byte_done = 1'b0; ack_bit = 1'b0;
  endtask

  task automatic engine_done();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  function automatic logic [7:0] flg();
    return {4'd0, xfer_trig, flag_xfer, flag_irq, flag_empty};
  endfunction

  task automatic t_reset();
    check("R1", "outputs after reset",
          {fmtless, master, dir, flag_empty, flag_irq, flag_xfer, xfer_trig, irq}, 8'h00);
    byte_end(1'b1); // ack_chk must be 0: all flags set on a nack
    check("R1", "ack check off after reset", flg(), 8'h0F);
    engine_done();
  endtask

  task automatic t_switch();
    wr(2'd0, 4'b0011);
    wr(2'd1, 4'b0001);
    check("R2", "enter unframed", {fmtless, master, dir}, 8'h07);
    wr(2'd1, 4'b0000);
    check("R2", "leave by write", {fmtless, master, dir}, 8'h03);
  endtask

  task automatic t_lock();
    wr(2'd0, 4'b0011);
    wr(2'd1, 4'b0001);
    wr(2'd0, 4'b1100);
    check("R5", "role write ignored", {master, dir}, 8'h03);
    byte_end(1'b1);
    check("R5", "ack_chk loaded in unframed mode", flg(), 8'h02);
    check("R5", "irq_en loaded in unframed mode", {7'd0, irq}, 8'h01);
    wr(2'd2, 4'b0000);
    wr(2'd1, 4'b0000);
    wr(2'd0, 4'b0000);
  endtask

  task automatic t_auto_return();
    wr(2'd0, 4'b0011);
    wr(2'd1, 4'b0001);
    @(negedge clk); scl_in = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R3", "still unframed after two edges", {7'd0, fmtless}, 8'h01);
    @(negedge clk);
    check("R3", "auto return on third edge", {7'd0, fmtless}, 8'h00);
    check("R4", "slave receive after return", {master, dir}, 8'h00);
    @(negedge clk); scl_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_no_false_edge();
    @(negedge clk); scl_in = 1'b0;
    repeat (4) @(negedge clk);
    wr(2'd1, 4'b0001);
    scl_in = 1'b1;
    repeat (5) @(negedge clk);
    check("R3", "low level and rising edge ignored", {7'd0, fmtless}, 8'h01);
    scl_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R3", "later fall returns", {7'd0, fmtless}, 8'h00);
    scl_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_idle_edges();
    wr(2'd0, 4'b0011);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); scl_in = 1'b0;
      repeat (3) @(negedge clk);
      scl_in = 1'b1;
      repeat (3) @(negedge clk);
    end
    check("R6", "edges in framed mode", {fmtless, master, dir}, 8'h03);
    wr(2'd0, 4'b0000);
  endtask

  task automatic t_ack_off();
    wr(2'd0, 4'b0000);
    byte_end(1'b0);
    check("R7", "ack=0 check off", flg(), 8'h0F);
    engine_done();
    check("R10", "engine clears all", flg(), 8'h00);
    byte_end(1'b1);
    check("R7", "ack=1 check off", flg(), 8'h0F);
    check("R10", "trigger follows request", {7'd0, xfer_trig}, 8'h01);
    engine_done();
    check("R10", "engine clears after nack", flg(), 8'h00);
  endtask

  task automatic t_ack_on();
    wr(2'd0, 4'b0100);
    byte_end(1'b0);
    check("R8", "ack with check on", flg(), 8'h0F);
    engine_done();
    byte_end(1'b1);
    check("R9", "nack with check on", flg(), 8'h02);
    repeat (3) @(negedge clk);
    check("R9", "no trigger after nack", {7'd0, xfer_trig}, 8'h00);
    wr(2'd2, 4'b0000);
  endtask

  task automatic t_irq();
    wr(2'd0, 4'b1100);
    byte_end(1'b1);
    check("R11", "irq raised", {7'd0, irq}, 8'h01);
    wr(2'd2, 4'b0101);
    check("R11", "irq drops with flag", {flag_irq, irq}, 8'h00);
    byte_end(1'b0);
    check("R11", "irq held off by trigger", {xfer_trig, irq}, 8'h02);
    engine_done();
    check("R11", "no irq after engine", {7'd0, irq}, 8'h00);
    wr(2'd0, 4'b0100);
    byte_end(1'b1);
    check("R11", "irq disabled", {flag_irq, irq}, 8'h02);
    wr(2'd2, 4'b0000);
  endtask

  task automatic t_sw_clear();
    wr(2'd0, 4'b0000);
    byte_end(1'b0);
    wr(2'd2, 4'b0110);
    check("R12", "clear empty only", flg(), 8'h0E);
    wr(2'd2, 4'b0111);
    check("R12", "ones leave flags", flg(), 8'h0E);
    wr(2'd2, 4'b0000);
    check("R12", "clear all", flg(), 8'h00);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 4'b0000;
    byte_done = 1'b1; ack_bit = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; byte_done = 1'b0;
    check("R12", "set beats clear", flg(), 8'h0F);
    engine_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_switch();
    t_lock();
    t_auto_return();
    t_no_false_edge();
    t_idle_edges();
    t_ack_off();
    t_ack_on();
    t_irq();
    t_sw_clear();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule